// File: doc/BRIEF.md
# Colour LCD Controller Register and Interrupt Block

This block is the software-visible control face of a colour LCD controller. A host reaches it through a simple word-addressed read/write bus over a 4 KB window. The block holds the four panel timing words, the base addresses of the upper and lower panel, a control word, an interrupt mask and a raw interrupt status. It also has a clear port and a read-only identification window at the top of the window. From the timing words it derives the active column and row counts. From the control word it derives the pixel-format, byte-order and colour-order fields, plus an "active" flag.

While the controller is active, an internal frame timer fires once every `FRAME_CYCLES` clock cycles. Each firing sets two interrupt status bits at once. A single level-sensitive interrupt line reports any status bit that is also enabled in the mask.

The `VARIANT` parameter selects one of three register layouts:
- 0: base layout.
- 1: board-modified layout.
- 2: extended layout.

Variants 1 and 2 exchange the addresses of the mask and control registers. Variant 2 also reports different identification bytes.

Top module: `lcdc_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `irq` and `active` are low, and `cols` and `rows` are 0.
- R2: Byte offsets 0x000, 0x004, 0x008 and 0x00C are read/write timing words 0–3. Offset 0x010 is the upper base and 0x014 is the lower base, all 32 bits wide. Offsets 0x02C and 0x030 read back the upper and lower base.
- R3: With `VARIANT`=0, offset 0x018 is the mask and 0x01C is control. With any other `VARIANT` the two are exchanged, for both reads and writes.
- R4: `active` = control[0] AND control[11]. `pix_mode` = control[3:1], `swap_rb` = control[8], `be_byte` = control[9] and `be_pixel` = control[10].
- R5: A write to timing word 0 sets `cols` to ((data AND 0xFC) + 4) * 4.
- R6: A write to timing word 1 sets `rows` to data[9:0] + 1.
- R7: While `active` is high, the frame timer fires once every `FRAME_CYCLES` cycles. The first firing comes `FRAME_CYCLES` cycles after the control write. Each firing sets status bit 2 and status bit 3 at the same clock edge. While `active` is low, status bits are never set.
- R8: Writing to offset 0x028 clears each status bit whose data bit is 1. That offset reads 0. A timer firing in the same cycle as a clear still sets its bits.
- R9: `irq` is high exactly when (status AND mask) is non-zero. Offset 0x020 reads the raw status. Offset 0x024 reads status AND mask.
- R10: Reading offset 0xFE0 + 4·k (k = 0..7) returns byte k of the identification sequence, zero-extended. Bytes 0 and 2 are 0x10 and 0x04 for variants 0 and 1, or 0x11 and 0x24 for variant 2. The remaining bytes, in order, are byte 1 = 0x11, then 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads from unmapped offsets, and from the palette area 0x200–0x3FF, return 0. Writes to them, and to the read-only status offsets 0x020 and 0x024, change no register.
- R12: Only bits [4:0] of the mask and status are stored. Their upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational from address) |
| irq | output | 1 | Level interrupt |
| active | output | 1 | Enable and power both set |
| pix_mode | output | 3 | Bits-per-pixel mode field |
| swap_rb | output | 1 | Red/blue order select |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order |
| cols | output | 11 | Active columns |
| rows | output | 11 | Active rows |

## Verification
The bench builds two instances on one shared bus:
- One instance uses `VARIANT`=0 and the other uses `VARIANT`=2. A single write therefore lands in the mask of one instance and the control word of the other, which exposes the address exchange and both identification sequences directly.
- Both instances use `FRAME_CYCLES`=20. This shortening brings the exact cycle of the first timer firing within reach, along with the stop on deactivation and the clear/mask interplay over several frames.

// File: rtl/lcdc_pkg.sv
// Shared definitions for the LCD controller register block.
// Assumes a 32-bit data bus; status field positions are fixed here.
package lcdc_pkg;

    // Implemented width of mask and raw status
    localparam int STAT_W      = 5;
    // Status bits raised by the frame timer
    localparam int ST_NEXTBASE = 2;
    localparam int ST_VCOMP    = 3;
    // Control word field positions
    localparam int CB_ENABLE   = 0;
    localparam int CB_MODE_LO  = 1;
    localparam int CB_SWAP     = 8;
    localparam int CB_BEBYTE   = 9;
    localparam int CB_BEPIX    = 10;
    localparam int CB_POWER    = 11;
    // Derived geometry width (max 1024)
    localparam int GEO_W       = 11;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TIM0,
        SEL_TIM1,
        SEL_TIM2,
        SEL_TIM3,
        SEL_UPPER,
        SEL_LOWER,
        SEL_MASK,
        SEL_CTRL,
        SEL_RAW,
        SEL_MSKD,
        SEL_CLEAR,
        SEL_UPCUR,
        SEL_LOCUR,
        SEL_IDENT
    } reg_sel_e;

    // Identification byte k for the given layout variant
    function automatic logic [7:0] ident_byte(input int variant, input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0:    b = (variant == 2) ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = (variant == 2) ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
// Address decoder: maps a byte offset to a register selector.
// Assumes word-aligned accesses; the low two address bits are ignored.
// The identification window occupies the last eight words of the window.
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int VARIANT = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);
    localparam int WIDX_W  = ADDR_W - 2;
    localparam int WORDS   = 1 << WIDX_W;
    localparam int ID_BASE = WORDS - 8;
    localparam int PAL_LO  = 'h80;
    localparam int PAL_HI  = 'hFF;

    logic [WIDX_W-1:0] widx;
    reg_sel_e          sel_w6;
    reg_sel_e          sel_w7;

    assign widx   = addr[ADDR_W-1:2];
    assign id_idx = widx[2:0];

    // Layout variant: choose which register words 6 and 7 reach
    generate
        if (VARIANT == 0) begin : g_base_layout
            assign sel_w6 = SEL_MASK;
            assign sel_w7 = SEL_CTRL;
        end else begin : g_swapped_layout
            assign sel_w6 = SEL_CTRL;
            assign sel_w7 = SEL_MASK;
        end
    endgenerate

    // Word index to selector
    always_comb begin
        sel = SEL_NONE;
        if (int'(widx) >= ID_BASE) begin
            sel = SEL_IDENT;
        end else if (int'(widx) >= PAL_LO && int'(widx) <= PAL_HI) begin
            sel = SEL_NONE;
        end else begin
            case (int'(widx))
                0:       sel = SEL_TIM0;
                1:       sel = SEL_TIM1;
                2:       sel = SEL_TIM2;
                3:       sel = SEL_TIM3;
                4:       sel = SEL_UPPER;
                5:       sel = SEL_LOWER;
                6:       sel = sel_w6;
                7:       sel = sel_w7;
                8:       sel = SEL_RAW;
                9:       sel = SEL_MSKD;
                10:      sel = SEL_CLEAR;
                11:      sel = SEL_UPCUR;
                12:      sel = SEL_LOCUR;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcdc_frame_timer.sv
// Frame timer: emits a one-cycle tick every FRAME_CYCLES cycles while active.
// A restart (control write) zeroes the count and suppresses the tick that cycle.
// Assumes FRAME_CYCLES >= 2.
module lcdc_frame_timer #(
    parameter int FRAME_CYCLES = 3_333_333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = active && !restart && (cnt == LAST);

    // Cycle counter, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lcdc_irq_unit.sv
// Interrupt unit: holds the mask and raw status and drives the level interrupt.
// A tick sets its bits even when a clear hits the same cycle.
module lcdc_irq_unit
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [STAT_W-1:0] mask_wdata,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic              tick,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    logic [STAT_W-1:0] tick_bits;
    logic [STAT_W-1:0] clr_eff;

    // Bits raised by one frame tick
    always_comb begin
        tick_bits = '0;
        tick_bits[ST_NEXTBASE] = tick;
        tick_bits[ST_VCOMP]    = tick;
    end

    assign clr_eff = clr_we ? clr_bits : '0;

    // Raw status: clear then set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_eff) | tick_bits;
        end
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_wdata;
        end
    end

    assign irq = |(status & mask);

endmodule

// File: rtl/lcdc_regs.sv
// LCD controller register block: timing, bases, control, interrupt and ID window.
// Assumes a single-cycle write bus; read data is combinational from the address.
// Geometry is captured on timing writes, not recomputed continuously.
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 32,
    parameter int VARIANT      = 0,
    parameter int FRAME_CYCLES = 3_333_333
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              active,
    output logic [2:0]        pix_mode,
    output logic              swap_rb,
    output logic              be_byte,
    output logic              be_pixel,
    output logic [GEO_W-1:0]  cols,
    output logic [GEO_W-1:0]  rows
);
    localparam int NTIM  = 4;
    localparam int PAD_W = DATA_W - STAT_W;

    reg_sel_e          sel;
    logic [2:0]        id_idx;
    logic              wr_en;
    logic [DATA_W-1:0] timing [NTIM];
    logic [DATA_W-1:0] upper_base;
    logic [DATA_W-1:0] lower_base;
    logic [DATA_W-1:0] ctrl;
    logic [STAT_W-1:0] raw_status;
    logic [STAT_W-1:0] int_mask;
    logic              frame_tick;
    logic              ctrl_we;

    lcdc_addr_dec #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    assign wr_en   = bus_sel && bus_wr;
    assign ctrl_we = wr_en && (sel == SEL_CTRL);

    // Timing words, one register each
    generate
        for (genvar t = 0; t < NTIM; t++) begin : g_timing
            localparam reg_sel_e MY_SEL = reg_sel_e'(int'(SEL_TIM0) + t);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    timing[t] <= '0;
                end else if (wr_en && sel == MY_SEL) begin
                    timing[t] <= bus_wdata;
                end
            end
        end
    endgenerate

    // Panel base addresses and control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_base <= '0;
            lower_base <= '0;
            ctrl       <= '0;
        end else if (wr_en) begin
            if (sel == SEL_UPPER) upper_base <= bus_wdata;
            if (sel == SEL_LOWER) lower_base <= bus_wdata;
            if (sel == SEL_CTRL)  ctrl       <= bus_wdata;
        end
    end

    // Geometry captured from timing-word writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cols <= '0;
            rows <= '0;
        end else if (wr_en) begin
            if (sel == SEL_TIM0) cols <= {7'(bus_wdata[7:2]) + 7'd1, 4'b0000};
            if (sel == SEL_TIM1) rows <= {1'b0, bus_wdata[9:0]} + 11'd1;
        end
    end

    // Control field decode
    assign active   = ctrl[CB_ENABLE] && ctrl[CB_POWER];
    assign pix_mode = ctrl[CB_MODE_LO +: 3];
    assign swap_rb  = ctrl[CB_SWAP];
    assign be_byte  = ctrl[CB_BEBYTE];
    assign be_pixel = ctrl[CB_BEPIX];

    lcdc_frame_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .restart (ctrl_we),
        .tick    (frame_tick)
    );

    lcdc_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (wr_en && sel == SEL_MASK),
        .mask_wdata (bus_wdata[STAT_W-1:0]),
        .clr_we     (wr_en && sel == SEL_CLEAR),
        .clr_bits   (bus_wdata[STAT_W-1:0]),
        .tick       (frame_tick),
        .status     (raw_status),
        .mask       (int_mask),
        .irq        (irq)
    );

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_TIM0:  bus_rdata = timing[0];
            SEL_TIM1:  bus_rdata = timing[1];
            SEL_TIM2:  bus_rdata = timing[2];
            SEL_TIM3:  bus_rdata = timing[3];
            SEL_UPPER: bus_rdata = upper_base;
            SEL_LOWER: bus_rdata = lower_base;
            SEL_UPCUR: bus_rdata = upper_base;
            SEL_LOCUR: bus_rdata = lower_base;
            SEL_CTRL:  bus_rdata = ctrl;
            SEL_MASK:  bus_rdata = {{PAD_W{1'b0}}, int_mask};
            SEL_RAW:   bus_rdata = {{PAD_W{1'b0}}, raw_status};
            SEL_MSKD:  bus_rdata = {{PAD_W{1'b0}}, raw_status & int_mask};
            SEL_IDENT: bus_rdata = DATA_W'(ident_byte(VARIANT, id_idx));
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lcdc_regs_chk.sv
// Assertion checker for lcdc_regs, attached by bind below.
// Relates bus writes, timer ticks and status/interrupt state over time.
module lcdc_regs_chk
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              active,
    input logic [GEO_W-1:0]  cols,
    input logic [GEO_W-1:0]  rows,
    input logic              tick,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] mask
);
    logic wr_t0, wr_t1, wr_clr;
    assign wr_t0  = bus_sel && bus_wr && (int'(bus_addr[ADDR_W-1:2]) == 0);
    assign wr_t1  = bus_sel && bus_wr && (int'(bus_addr[ADDR_W-1:2]) == 1);
    assign wr_clr = bus_sel && bus_wr && (int'(bus_addr[ADDR_W-1:2]) == 10);

    assert_cols_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t0 |=> cols == GEO_W'((({24'b0, $past(bus_wdata[7:0])} & 32'hFC) + 32'd4) * 32'd4));

    assert_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_t1 |=> rows == GEO_W'({22'b0, $past(bus_wdata[9:0])} + 32'd1));

    assert_tick_sets_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (status[ST_NEXTBASE] && status[ST_VCOMP]));

    assert_no_tick_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !tick);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !tick) |=> ((status & $past(bus_wdata[STAT_W-1:0])) == '0));

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .active    (active),
    .cols      (cols),
    .rows      (rows),
    .tick      (frame_tick),
    .status    (raw_status),
    .mask      (int_mask)
);

// File: tb/test_lcdc_regs.sv
`timescale 1ns/100ps
module test_lcdc_regs;
    localparam int FC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_m, rd_a;
    logic        irq_m, irq_a, act_m, act_a;
    logic [2:0]  pm_m, pm_a;
    logic        sw_m, sw_a, bb_m, bb_a, bp_m, bp_a;
    logic [10:0] cols_m, cols_a, rows_m, rows_a;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lcdc_regs #(.VARIANT(0), .FRAME_CYCLES(FC)) i_lcdc_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_m),
        .irq(irq_m), .active(act_m), .pix_mode(pm_m), .swap_rb(sw_m),
        .be_byte(bb_m), .be_pixel(bp_m), .cols(cols_m), .rows(rows_m));

    lcdc_regs #(.VARIANT(2), .FRAME_CYCLES(FC)) i_lcdc_regs_alt (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
        .irq(irq_a), .active(act_a), .pix_mode(pm_a), .swap_rb(sw_a),
        .be_byte(bb_a), .be_pixel(bp_a), .cols(cols_a), .rows(rows_a));

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    // Write then read back on the VARIANT 0 instance
    localparam vec_t VECS [12] = '{
        '{12'h000, 32'hA5A5_01FF, 32'hA5A5_01FF},  // R2
        '{12'h004, 32'h1234_0005, 32'h1234_0005},  // R2
        '{12'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2
        '{12'h00C, 32'h0000_00FF, 32'h0000_00FF},  // R2
        '{12'h010, 32'h8000_1000, 32'h8000_1000},  // R2
        '{12'h014, 32'h8010_0000, 32'h8010_0000},  // R2
        '{12'h018, 32'hFFFF_FFE0, 32'h0000_0000},  // R12 mask keeps [4:0] only
        '{12'h01C, 32'h0000_0700, 32'h0000_0700},  // R3 control at 0x01C
        '{12'h034, 32'h1111_1111, 32'h0000_0000},  // R11 unmapped
        '{12'h200, 32'h2222_2222, 32'h0000_0000},  // R11 palette area
        '{12'h028, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 clear port reads 0
        '{12'h020, 32'h0000_001F, 32'h0000_0000}   // R11 raw status write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; the write commits on the rising edge between
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Combinational read sampled away from any edge
    task automatic bus_read(input logic [11:0] a, output logic [31:0] m, output logic [31:0] al);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        m = rd_m; al = rd_a;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] m, a;
        logic [7:0]  idm [8];
        logic [7:0]  ida [8];
        idm = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        ida = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

        do_reset();
        bus_read(12'h000, m, a); check("R1 timing0 after reset", m, 0);
        bus_read(12'h01C, m, a); check("R1 control after reset", m, 0);
        check("R1 irq after reset", {31'b0, irq_m}, 0);
        check("R1 cols after reset", {21'b0, cols_m}, 0);
        @(negedge clk);

        // Table walk (R2 R3 R8 R11 R12)
        for (int i = 0; i < 12; i++) begin
            bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].addr, m, a);
            check("R2/R3/R11/R12 table", m, VECS[i].expect_rd);
            @(negedge clk);
        end
        bus_read(12'h02C, m, a); check("R2 upper base mirror", m, 32'h8000_1000);
        bus_read(12'h030, m, a); check("R2 lower base mirror", m, 32'h8010_0000);
        @(negedge clk);

        // Reset mid-run clears everything (R1)
        do_reset();
        bus_read(12'h010, m, a); check("R1 upper base after reset", m, 0);
        check("R1 rows after reset", {21'b0, rows_m}, 0);
        check("R1 active after reset", {31'b0, act_m}, 0);
        @(negedge clk);

        // Geometry (R5 R6)
        bus_write(12'h000, 32'h0000_01FF); check("R5 cols max", {21'b0, cols_m}, 1024);
        bus_write(12'h000, 32'h0000_0003); check("R5 cols min", {21'b0, cols_m}, 16);
        bus_write(12'h000, 32'h0000_0050); check("R5 cols mid", {21'b0, cols_m}, 336);
        bus_write(12'h004, 32'hFFFF_FFFF); check("R6 rows max", {21'b0, rows_m}, 1024);
        bus_write(12'h004, 32'h0000_0000); check("R6 rows min", {21'b0, rows_m}, 1);

        // Control decode (R4); alt instance takes this as its mask
        bus_write(12'h01C, 32'h0000_070A);
        check("R4 pix_mode", {29'b0, pm_m}, 5);
        check("R4 order bits", {29'b0, sw_m, bb_m, bp_m}, 3'b111);
        check("R4 inactive without enable/power", {31'b0, act_m}, 0);

        // Identification window (R10)
        for (int k = 0; k < 8; k++) begin
            bus_read(12'hFE0 + 12'(4 * k), m, a);
            check("R10 ident base", m, {24'b0, idm[k]});
            check("R10 ident extended", a, {24'b0, ida[k]});
        end
        @(negedge clk);

        // Layout exchange (R3)
        bus_write(12'h018, 32'h0000_0801);
        check("R3 alt active via 0x018", {31'b0, act_a}, 1);
        check("R3 base not active", {31'b0, act_m}, 0);
        bus_read(12'h018, m, a);
        check("R3 base 0x018 is mask", m, 32'h1);
        check("R3 alt 0x018 is control", a, 32'h801);
        bus_read(12'h01C, m, a);
        check("R3 alt 0x01C is mask", a, 32'h0A);
        check("R3 base 0x01C is control", m, 32'h70A);
        @(negedge clk);

        // Frame timer on base instance (R7)
        bus_write(12'h01C, 32'h0000_0801);
        check("R4 active with enable and power", {31'b0, act_m}, 1);
        repeat (FC - 1) @(posedge clk);
        @(negedge clk);
        bus_read(12'h020, m, a); check("R7 no status before frame period", m, 0);
        @(negedge clk);
        bus_read(12'h020, m, a); check("R7 both bits at frame period", m, 32'h0C);
        check("R7 alt instance ticked", a, 32'h0C);
        check("R9 irq low, mask lacks bits", {31'b0, irq_m}, 0);
        @(negedge clk);

        // Deactivate, then interrupt logic (R8 R9)
        bus_write(12'h01C, 32'h0000_0001);
        check("R7 inactive with power clear", {31'b0, act_m}, 0);
        bus_write(12'h018, 32'h0000_0004);
        check("R9 irq high with mask hit", {31'b0, irq_m}, 1);
        bus_read(12'h024, m, a); check("R9 masked status", m, 32'h04);
        @(negedge clk);
        bus_write(12'h028, 32'h0000_0004);
        bus_read(12'h020, m, a); check("R8 clear one bit", m, 32'h08);
        check("R9 irq low after clear", {31'b0, irq_m}, 0);
        @(negedge clk);
        bus_write(12'h018, 32'h0000_0008);
        check("R9 irq follows mask write", {31'b0, irq_m}, 1);
        bus_write(12'h028, 32'hFFFF_FFFF);
        check("R8 irq low after full clear", {31'b0, irq_m}, 0);
        repeat (3 * FC) @(negedge clk);
        bus_read(12'h020, m, a); check("R7 no ticks while inactive", m, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule